// File: doc/BRIEF.md
# Triggered SPI Command Replay Store

This block holds a short, fixed SPI program: a list of 16-bit command words plus a separate list of transmit data words. Software loads each list by writing repeatedly to a push register. Each time the external trigger pulses while replay is enabled, the block streams both lists from their first entry to a downstream SPI command executor over two valid/ready channels.

The lists are not consumed by a replay, so every accepted trigger sends the same program again. A clear register empties both lists and drops any replay in flight. A read-only geometry register reports how many address bits each list has, and a status register reports sticky overflow flags and whether a replay is running. Command words are passed through unchanged and are never decoded, so a program that ends in a synchronisation command and one that does not are handled the same way.

Top module: `cmd_replay_store`

## Requirements
- R1: After reset the enable bit (offset 0, bit 0) reads 0, the status register (offset 3) reads 0, and neither stream is valid.
- R2: The geometry register at offset 2 reads the command list address width in bits [7:0] and the data list address width in bits [15:8]; each list holds 2^width entries (default 16).
- R3: Each write to offset 4 appends wdata[15:0] to the command list and each write to offset 5 appends the data word to the data list; replay presents them in the order they were written.
- R4: A push to a full list is dropped, and it sets a sticky flag in the status register: bit 0 for the command list, bit 1 for the data list.
- R5: A trigger pulse while the enable bit is 1, no replay is running, clear is 0 and the command list is not empty starts a replay, and status bit 2 reads 1 while it runs.
- R6: Every replay starts both lists at entry 0 and sends every stored word, so repeated triggers send identical sequences.
- R7: A trigger while the enable bit is 0 starts nothing.
- R8: A trigger that arrives while a replay is running is ignored and not queued.
- R9: While a stream is valid and not ready, it stays valid and its word does not change.
- R10: A replay ends only after the last command word and the last data word have both been accepted; an empty data list never raises its valid.
- R11: While bit 0 of the clear register (offset 1) is 1, both lists are emptied, both overflow flags are cleared, any running replay is dropped and triggers start nothing; writing 0 afterwards allows loading again.
- R12: Command words are not interpreted: a program whose last word is a sync command (upper nibble 3) and one whose last word is any other value replay identically.
- R13: Clearing the enable bit during a replay lets that replay finish; only later triggers are blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Register write offset |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 3 | Register read offset |
| reg_rdata | output | 32 | Register read data (combinational) |
| trigger | input | 1 | Replay request pulse |
| cmd_valid | output | 1 | Command stream valid |
| cmd_ready | input | 1 | Command stream ready |
| cmd_word | output | 16 | Command stream word |
| tx_valid | output | 1 | Data stream valid |
| tx_ready | input | 1 | Data stream ready |
| tx_word | output | DATA_W | Data stream word |

## Verification
The replay is driven with the downstream always ready, with pseudo-random ready on each stream, and with ready held low across trigger, disable and clear writes. The always-ready pattern shows order and completeness, the random pattern shows that backpressure neither drops nor repeats words and that a second trigger replays from entry 0, and the held-low pattern pins a replay open so that a second trigger, an enable drop or a clear lands mid-replay and can be told apart. Lists filled past capacity, an empty data list and programs with and without a trailing sync word cover the boundaries.

// File: rtl/crm_pkg.sv
package crm_pkg;
   localparam int REG_AW = 3;
   localparam int BUS_W  = 32;
   localparam int CMD_W  = 16;

   typedef enum logic [REG_AW-1:0] {
      OFS_CTRL  = 3'd0,
      OFS_CLEAR = 3'd1,
      OFS_GEOM  = 3'd2,
      OFS_STAT  = 3'd3,
      OFS_CPUSH = 3'd4,
      OFS_DPUSH = 3'd5
   } crm_ofs_e;
endpackage

// File: rtl/crm_store.sv
module crm_store #(
   parameter int W  = 16,
   parameter int AW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [W-1:0]  push_word,
   input  logic [AW-1:0] rd_idx,
   output logic [W-1:0]  rd_word,
   output logic [AW:0]   count,
   output logic          overflow
);
   localparam int DEPTH = 1 << AW;
   localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);

   generate
      if (AW < 1 || AW > 8) begin : g_bad_aw
         $error("crm_store: AW must be 1..8");
      end
      if (W < 1) begin : g_bad_w
         $error("crm_store: W must be positive");
      end
   endgenerate

   logic [W-1:0] mem [DEPTH];
   logic         full;

   assign full = (count == FULL_LVL);

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         count    <= '0;
         overflow <= 1'b0;
      end else if (push) begin
         if (full) overflow <= 1'b1;
         else      count    <= count + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst_n && !flush && push && !full)
         mem[count[AW-1:0]] <= push_word;
   end

   assign rd_word = mem[rd_idx];
endmodule

// File: rtl/crm_reader.sv
module crm_reader #(
   parameter int AW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          run,
   input  logic [AW:0]   count,
   input  logic          ready,
   output logic          valid,
   output logic [AW-1:0] idx,
   output logic [AW:0]   rp,
   output logic          exhausted
);
   assign exhausted = (rp >= count);
   assign valid     = run && !exhausted;
   assign idx       = rp[AW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n)             rp <= '0;
      else if (start)         rp <= '0;
      else if (valid && ready) rp <= rp + 1'b1;
   end
endmodule

// File: rtl/crm_regs.sv
module crm_regs
   import crm_pkg::*;
#(
   parameter int CMD_AW  = 4,
   parameter int DATA_AW = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [REG_AW-1:0] waddr,
   input  logic              wbit0,
   input  logic [REG_AW-1:0] raddr,
   input  logic              cmd_ovf,
   input  logic              tx_ovf,
   input  logic              busy,
   output logic              en,
   output logic              clear_q,
   output logic              cmd_push,
   output logic              tx_push,
   output logic [BUS_W-1:0]  rdata
);
   crm_ofs_e wsel, rsel;
   assign wsel = crm_ofs_e'(waddr);
   assign rsel = crm_ofs_e'(raddr);

   assign cmd_push = we && (wsel == OFS_CPUSH);
   assign tx_push  = we && (wsel == OFS_DPUSH);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en      <= 1'b0;
         clear_q <= 1'b0;
      end else if (we) begin
         if (wsel == OFS_CTRL)  en      <= wbit0;
         if (wsel == OFS_CLEAR) clear_q <= wbit0;
      end
   end

   always_comb begin
      rdata = '0;
      case (rsel)
         OFS_CTRL:  rdata[0] = en;
         OFS_CLEAR: rdata[0] = clear_q;
         OFS_GEOM:  rdata[15:0] = {8'(DATA_AW), 8'(CMD_AW)};
         OFS_STAT:  rdata[2:0] = {busy, tx_ovf, cmd_ovf};
         default:   rdata = '0;
      endcase
   end
endmodule

// File: rtl/cmd_replay_store.sv
module cmd_replay_store
   import crm_pkg::*;
#(
   parameter int CMD_AW  = 4,
   parameter int DATA_AW = 4,
   parameter int DATA_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [2:0]        reg_waddr,
   input  logic [31:0]       reg_wdata,
   input  logic [2:0]        reg_raddr,
   output logic [31:0]       reg_rdata,
   input  logic              trigger,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [15:0]       cmd_word,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic [DATA_W-1:0] tx_word
);
   generate
      if (DATA_W < 1 || DATA_W > BUS_W) begin : g_bad_dw
         $error("cmd_replay_store: DATA_W must be 1..BUS_W");
      end
   endgenerate

   logic              en, clear_q, cmd_push, tx_push, busy;
   logic              cmd_ovf, tx_ovf;
   logic [CMD_AW:0]   cmd_count, cmd_rp;
   logic [DATA_AW:0]  tx_count, tx_rp;
   logic [CMD_AW-1:0] cmd_idx;
   logic [DATA_AW-1:0] tx_idx;
   logic              cmd_exh, tx_exh, start, run;
   logic [DATA_W-1:0] tx_push_word;

   generate
      if (DATA_W == BUS_W) begin : g_full_dw
         assign tx_push_word = reg_wdata;
      end else begin : g_narrow_dw
         assign tx_push_word = reg_wdata[DATA_W-1:0];
      end
   endgenerate

   crm_regs #(.CMD_AW(CMD_AW), .DATA_AW(DATA_AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .waddr(reg_waddr),
      .wbit0(reg_wdata[0]), .raddr(reg_raddr), .cmd_ovf(cmd_ovf),
      .tx_ovf(tx_ovf), .busy(busy), .en(en), .clear_q(clear_q),
      .cmd_push(cmd_push), .tx_push(tx_push), .rdata(reg_rdata)
   );

   crm_store #(.W(CMD_W), .AW(CMD_AW)) u_cmd_mem (
      .clk(clk), .rst_n(rst_n), .flush(clear_q), .push(cmd_push),
      .push_word(reg_wdata[CMD_W-1:0]), .rd_idx(cmd_idx), .rd_word(cmd_word),
      .count(cmd_count), .overflow(cmd_ovf)
   );

   crm_store #(.W(DATA_W), .AW(DATA_AW)) u_tx_mem (
      .clk(clk), .rst_n(rst_n), .flush(clear_q), .push(tx_push),
      .push_word(tx_push_word), .rd_idx(tx_idx), .rd_word(tx_word),
      .count(tx_count), .overflow(tx_ovf)
   );

   assign run   = busy && !clear_q;
   assign start = trigger && en && !busy && !clear_q && (cmd_count != '0);

   crm_reader #(.AW(CMD_AW)) u_cmd_rd (
      .clk(clk), .rst_n(rst_n), .start(start), .run(run), .count(cmd_count),
      .ready(cmd_ready), .valid(cmd_valid), .idx(cmd_idx), .rp(cmd_rp),
      .exhausted(cmd_exh)
   );

   crm_reader #(.AW(DATA_AW)) u_tx_rd (
      .clk(clk), .rst_n(rst_n), .start(start), .run(run), .count(tx_count),
      .ready(tx_ready), .valid(tx_valid), .idx(tx_idx), .rp(tx_rp),
      .exhausted(tx_exh)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || clear_q)       busy <= 1'b0;
      else if (start)              busy <= 1'b1;
      else if (cmd_exh && tx_exh)  busy <= 1'b0;
   end
endmodule

// File: rtl/crm_replay_chk.sv
module crm_replay_chk #(
   parameter int CMD_AW  = 4,
   parameter int DATA_AW = 4,
   parameter int DATA_W  = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               clear_q,
   input logic               en,
   input logic               busy,
   input logic               trigger,
   input logic               cmd_valid,
   input logic               cmd_ready,
   input logic [15:0]        cmd_word,
   input logic               tx_valid,
   input logic               tx_ready,
   input logic [DATA_W-1:0]  tx_word,
   input logic               cmd_ovf,
   input logic [CMD_AW:0]    cmd_count,
   input logic [DATA_AW:0]   tx_count,
   input logic [CMD_AW:0]    cmd_rp,
   input logic [DATA_AW:0]   tx_rp
);
   localparam logic [CMD_AW:0] CMD_CAP = (CMD_AW+1)'(1 << CMD_AW);

   AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n || clear_q)
      cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_word)); // R9
   AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n || clear_q)
      tx_valid && !tx_ready |=> tx_valid && $stable(tx_word)); // R9
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !cmd_valid && !tx_valid); // R10
   AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(trigger) && $past(en)); // R7
   AST_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> cmd_rp == '0 && tx_rp == '0); // R6
   AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n || clear_q)
      busy && trigger |=> cmd_rp >= $past(cmd_rp)); // R8
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ovf && !clear_q |=> cmd_ovf); // R4
   AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      clear_q |=> cmd_count == '0 && tx_count == '0 && !busy); // R11
   AST_CMD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_count <= CMD_CAP); // R3
endmodule

bind cmd_replay_store crm_replay_chk #(
   .CMD_AW(CMD_AW), .DATA_AW(DATA_AW), .DATA_W(DATA_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .clear_q(clear_q), .en(en), .busy(busy),
   .trigger(trigger), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
   .cmd_word(cmd_word), .tx_valid(tx_valid), .tx_ready(tx_ready),
   .tx_word(tx_word), .cmd_ovf(cmd_ovf), .cmd_count(cmd_count),
   .tx_count(tx_count), .cmd_rp(cmd_rp), .tx_rp(tx_rp)
);

// File: tb/sim_cmd_replay_store.sv
`timescale 1ns/1ps
module sim_cmd_replay_store;
   localparam int DW = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_waddr = '0;
   logic [31:0] reg_wdata = '0;
   logic [2:0]  reg_raddr = '0;
   logic [31:0] reg_rdata;
   logic        trigger = 1'b0;
   logic        cmd_valid, tx_valid;
   logic        cmd_ready = 1'b0, tx_ready = 1'b0;
   logic [15:0] cmd_word;
   logic [DW-1:0] tx_word;

   int n_chk = 0, n_fail = 0;
   int cmd_mode = 0, tx_mode = 0;
   logic [15:0] lfsr = 16'hACE1;

   logic [15:0] m_cmd[$];
   logic [31:0] m_tx[$];
   logic [15:0] exp_cmd[$];
   logic [31:0] exp_tx[$];
   logic        p_cv = 0, p_cr = 0, p_tv = 0, p_tr = 0;
   logic [15:0] p_cw = '0;
   logic [31:0] p_tw = '0;

   always #2.5 clk = ~clk;

   cmd_replay_store #(.CMD_AW(4), .DATA_AW(4), .DATA_W(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
      .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
      .trigger(trigger), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_word(cmd_word), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .tx_word(tx_word)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // ready pattern driver
   always @(negedge clk) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cmd_ready = (cmd_mode == 0) ? 1'b1 : (cmd_mode == 1) ? lfsr[0] : 1'b0;
      tx_ready  = (tx_mode == 0)  ? 1'b1 : (tx_mode == 1)  ? lfsr[3] : 1'b0;
   end

   // scoreboard monitor
   always begin
      @(negedge clk);
      #2;
      if (rst_n) begin
         if (p_cv && !p_cr)
            chk("R9 cmd hold", {15'd0, cmd_valid, cmd_word}, {15'd0, 1'b1, p_cw});
         if (p_tv && !p_tr)
            chk("R9 tx hold", {31'd0, tx_valid}, 32'd1);
         if (p_tv && !p_tr && tx_valid)
            chk("R9 tx word hold", tx_word, p_tw);
         if (cmd_valid && cmd_ready) begin
            if (exp_cmd.size() == 0) chk("R6/R8 unexpected cmd", {16'd0, cmd_word}, 32'hFFFF_FFFF);
            else chk("R3/R6 cmd order", {16'd0, cmd_word}, {16'd0, exp_cmd.pop_front()});
         end
         if (tx_valid && tx_ready) begin
            if (exp_tx.size() == 0) chk("R6/R8 unexpected tx", tx_word, 32'hDEAD_0BAD);
            else chk("R3/R6 tx order", tx_word, exp_tx.pop_front());
         end
         p_cv = cmd_valid; p_cr = cmd_ready; p_cw = cmd_word;
         p_tv = tx_valid;  p_tr = tx_ready;  p_tw = tx_word;
      end
   end

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] v);
      @(negedge clk);
      reg_raddr = a;
      #1 v = reg_rdata;
   endtask

   task automatic push_cmd(input logic [15:0] c);
      wr(3'd4, {16'd0, c});
      if (m_cmd.size() < 16) m_cmd.push_back(c);
   endtask

   task automatic push_tx(input logic [31:0] d);
      wr(3'd5, d);
      if (m_tx.size() < 16) m_tx.push_back(d);
   endtask

   task automatic fire(input bit expect_run);
      @(negedge clk);
      trigger = 1'b1;
      if (expect_run) begin
         foreach (m_cmd[i]) exp_cmd.push_back(m_cmd[i]);
         foreach (m_tx[i])  exp_tx.push_back(m_tx[i]);
      end
      @(negedge clk);
      trigger = 1'b0;
   endtask

   task automatic wait_idle();
      logic [31:0] v;
      for (int k = 0; k < 2000; k++) begin
         rd(3'd3, v);
         if (v[2] == 1'b0) break;
      end
      repeat (4) @(negedge clk);
   endtask

   task automatic flush_sb();
      exp_cmd.delete(); exp_tx.delete();
      p_cv = 0; p_tv = 0;
   endtask

   initial begin
      logic [31:0] v;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(3'd0, v); chk("R1 ctrl", v, 32'd0);
      rd(3'd3, v); chk("R1 status", v, 32'd0);
      chk("R1 valids", {30'd0, cmd_valid, tx_valid}, 32'd0);
      // R2 geometry
      rd(3'd2, v); chk("R2 geometry", v, 32'h0000_0404);

      // R3 R5 R12: program ending with a sync command
      push_cmd(16'h2101); push_cmd(16'h0102); push_cmd(16'h3001);
      push_tx(32'h1111_0001); push_tx(32'h2222_0002);
      wr(3'd0, 32'd1);
      fire(1);
      rd(3'd3, v); chk("R5 busy while running", {31'd0, v[2]}, 32'd1);
      wait_idle();
      chk("R5 all cmds sent", exp_cmd.size(), 0);
      chk("R5 all tx sent", exp_tx.size(), 0);

      // R6 R9: replay again under random backpressure
      cmd_mode = 1; tx_mode = 1;
      fire(1); wait_idle();
      fire(1); wait_idle();
      chk("R6 replay complete", exp_cmd.size() + exp_tx.size(), 0);

      // R10: data stalled keeps replay open after commands drain
      cmd_mode = 0; tx_mode = 2;
      fire(1);
      repeat (20) @(negedge clk);
      chk("R10 cmds drained", exp_cmd.size(), 0);
      rd(3'd3, v); chk("R10 busy until data drained", {31'd0, v[2]}, 32'd1);
      tx_mode = 1;
      wait_idle();
      chk("R10 data drained", exp_tx.size(), 0);

      // R7: disabled trigger ignored
      cmd_mode = 0; tx_mode = 0;
      wr(3'd0, 32'd0);
      fire(0);
      repeat (10) @(negedge clk);
      rd(3'd3, v); chk("R7 no replay when disabled", {31'd0, v[2]}, 32'd0);
      chk("R7 cmd idle", {31'd0, cmd_valid}, 32'd0);

      // R8: second trigger during replay is not queued
      wr(3'd0, 32'd1);
      cmd_mode = 2; tx_mode = 2;
      fire(1);
      fire(0);
      cmd_mode = 1; tx_mode = 1;
      wait_idle();
      repeat (30) @(negedge clk);
      chk("R8 single replay", exp_cmd.size() + exp_tx.size(), 0);
      rd(3'd3, v); chk("R8 idle after one replay", {31'd0, v[2]}, 32'd0);

      // R13: disabling mid-replay lets it finish
      cmd_mode = 2; tx_mode = 2;
      fire(1);
      wr(3'd0, 32'd0);
      cmd_mode = 0; tx_mode = 0;
      wait_idle();
      chk("R13 replay finished after disable", exp_cmd.size() + exp_tx.size(), 0);
      wr(3'd0, 32'd1);

      // R4: overfill both lists
      wr(3'd1, 32'd1); wr(3'd1, 32'd0);
      m_cmd.delete(); m_tx.delete();
      for (int i = 0; i < 17; i++) push_cmd(16'h0A00 + 16'(i));
      rd(3'd3, v); chk("R4 cmd overflow flag only", v, 32'd1);
      for (int i = 0; i < 17; i++) push_tx(32'hB000_0000 + i);
      rd(3'd3, v); chk("R4 both overflow flags", v, 32'd3);
      cmd_mode = 1; tx_mode = 1;
      fire(1); wait_idle();
      chk("R3 capacity 16 replayed", exp_cmd.size() + exp_tx.size(), 0);
      rd(3'd3, v); chk("R4 flags sticky", v, 32'd3);

      // R11: clear mid-replay
      cmd_mode = 2; tx_mode = 2;
      fire(0);
      wr(3'd1, 32'd1);
      flush_sb();
      rd(3'd3, v); chk("R11 status cleared", v, 32'd0);
      chk("R11 streams dropped", {30'd0, cmd_valid, tx_valid}, 32'd0);
      fire(0);
      repeat (5) @(negedge clk);
      rd(3'd3, v); chk("R11 trigger ignored during clear", v, 32'd0);
      wr(3'd1, 32'd0);
      m_cmd.delete(); m_tx.delete();
      cmd_mode = 0; tx_mode = 0;
      fire(0);
      repeat (10) @(negedge clk);
      rd(3'd3, v); chk("R11 empty list no replay", v, 32'd0);

      // R12 R10: program without sync end, no data words
      push_cmd(16'h4003); push_cmd(16'h1207); push_cmd(16'h0007);
      cmd_mode = 1;
      fire(1); wait_idle();
      chk("R12 non-sync program replayed", exp_cmd.size(), 0);
      chk("R10 empty data list stays quiet", exp_tx.size(), 0);

      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule